// File: doc/BRIEF.md
# Serial Register-File Slave

This block is the slave side of a synchronous serial port that lets a host read and write a bank of thirty-two 8-bit registers. A transfer opens when the host pulls chip select low. The first byte is an instruction that holds a read/write flag, a byte count of one to four and a 5-bit start address. The data bytes follow, and after each one the byte address moves by one. It moves down when the port is in MSB-first order and up when it is in LSB-first order. Register 0 is the port's own configuration. It holds the bit order, the choice between a shared data pin (3-wire) and a separate output pin (4-wire), a self-clearing soft reset and a stored long-instruction flag. A write to register 0 changes the port's behaviour at once, so it also affects the bytes that follow in the same transfer.

The block runs on a fast system clock. It finds serial clock edges by comparing each sample with the one before, so the system clock must be well above twice the serial clock rate. Input bits are taken on serial clock rising edges, and read bits are launched on falling edges. A combinational parallel port lets other logic on the chip read any register at any time.

Top module: `serreg_slave`

## Requirements
- R1: While `spi_csn` is high, `sdio_oe` and `sdo_oe` are both 0. Raising `spi_csn` in the middle of a byte throws the partial byte away, and the next transfer starts again with an instruction byte.
- R2: The instruction byte is read as a value b. b[7]=1 means read and b[7]=0 means write. b[6:5] is the data byte count minus one (00 gives 1 byte, 11 gives 4). b[4:0] is the start address.
- R3: Bits are taken from `sdio_i` on rising edges of `spi_sclk`. When register 0 bit 6 is 0, the first bit of every byte is bit 7 and the last is bit 0. When it is 1, the first bit is bit 0 and the last is bit 7.
- R4: After each data byte the address steps by -1 when register 0 bit 6 is 0 and by +1 when it is 1, wrapping modulo 32. Bytes beyond the instruction's count write nothing.
- R5: In a read, each bit is driven on the falling edge of `spi_sclk` before the rising edge on which the host takes it. The first data bit follows the falling edge after the last instruction bit. Each byte is the current content of the addressed register.
- R6: When register 0 bit 7 is 0, read data leaves on `sdo_o` with `sdo_oe`=1 during the read data bytes, and `sdio_oe` stays 0. When bit 7 is 1, read data leaves on `sdio_o` with `sdio_oe`=1, and `sdo_oe` stays 0. Both enables are 0 outside read data bytes.
- R7: A write to register 0 takes effect in the cycle its last bit is taken. Both the address step after that byte and the bit order of every later byte in the same transfer follow the new value.
- R8: Writing register 0 with bit 5 set returns every register except register 0 and register `HOLD_IDX` (default 4) to its default value. Register 0 stores the written value with bit 5 cleared, so bit 5 always reads as 0.
- R9: After `rst_n` the registers hold their defaults: register 0 holds 0x00, and register a (a from 1 to 31) holds {3'b101, a[4:0]}. `rf_data` always equals the register selected by `rf_addr`.
- R10: From any configuration, the port returns to register 0 = 0x00 after this sequence: 1 to 7 zero bits, `spi_csn` high, then one transfer of three 0x00 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Active-low chip select |
| spi_sclk | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Serial data into the port |
| sdio_o | output | 1 | Read data on the shared pin in 3-wire mode |
| sdio_oe | output | 1 | Output enable of the shared pin |
| sdo_o | output | 1 | Read data on the separate output pin in 4-wire mode |
| sdo_oe | output | 1 | Output enable of the separate output pin |
| rf_addr | input | 5 | Parallel read address |
| rf_data | output | 8 | Parallel read data |

## Verification
The hard case is a byte that writes register 0. In the same cycle it stores the new configuration, steps the address and sets the bit order for the next byte. The bench provokes this with a two-byte LSB-first write that starts at address 0 and clears the order bit. It judges the result by whether the second byte lands in register 31 with its bits assembled MSB-first. A soft reset written in a multi-register scenario tests a write and a bank-wide restore landing on one edge. A behavioural model of the whole register bank is compared with the parallel port on every clock.

// File: rtl/serreg_pkg.sv
package serreg_pkg;

    localparam int ADDR_W        = 5;
    localparam int DATA_W        = 8;
    localparam int CFG_BIDIR_BIT = 7;
    localparam int CFG_LSB_BIT   = 6;
    localparam int CFG_SRST_BIT  = 5;
    localparam int CNT_W         = 2;

    typedef enum logic [1:0] {
        PH_INSTR,
        PH_WR,
        PH_RD,
        PH_DONE
    } phase_e;

    // Power-up value of each entry; entry 0 (configuration) is all zero.
    function automatic logic [DATA_W-1:0] reg_default(input int idx);
        if (idx == 0) return '0;
        return {3'b101, ADDR_W'(idx)};
    endfunction

endpackage

// File: rtl/serreg_edge.sv
module serreg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sig_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = sig_i & ~st_q.prev;
    assign fall_o = ~sig_i & st_q.prev;

endmodule

// File: rtl/serreg_shifter.sv
module serreg_shifter #(
    parameter  int W  = 8,
    localparam int CW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          take_i,
    input  logic          bit_i,
    input  logic          lsb_first_i,
    output logic          done_o,
    output logic [W-1:0]  byte_o,
    output logic [CW-1:0] count_o
);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [CW-1:0] cnt;
    } shf_st_t;

    shf_st_t      st_d, st_q;
    logic [W-1:0] merged;

    always_comb begin
        st_d   = st_q;
        done_o = 1'b0;
        merged = lsb_first_i ? {bit_i, st_q.sh[W-1:1]} : {st_q.sh[W-2:0], bit_i};
        if (clr_i) begin
            st_d = '0;
        end else if (take_i) begin
            st_d.sh = merged;
            if (st_q.cnt == CW'(W - 1)) begin
                done_o   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte_o  = merged;
    assign count_o = st_q.cnt;

endmodule

// File: rtl/serreg_regfile.sv
module serreg_regfile
    import serreg_pkg::*;
#(
    parameter  int AW       = ADDR_W,
    parameter  int DW       = DATA_W,
    parameter  int HOLD_IDX = 4,
    localparam int NREG     = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o,
    input  logic [AW-1:0] paddr_i,
    output logic [DW-1:0] pdata_o,
    output logic          cfg_lsb_o,
    output logic          cfg_bidir_o
);

    logic [DW-1:0] mem_d [NREG];
    logic [DW-1:0] mem_q [NREG];
    logic          srst;

    always_comb begin
        srst = we_i && (waddr_i == '0) && wdata_i[CFG_SRST_BIT];
        for (int i = 0; i < NREG; i++) begin
            mem_d[i] = mem_q[i];
            if (srst && (i != 0) && (i != HOLD_IDX)) mem_d[i] = DW'(reg_default(i));
        end
        if (we_i) begin
            mem_d[waddr_i] = wdata_i;
            if (srst) mem_d[0][CFG_SRST_BIT] = 1'b0;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= DW'(reg_default(g));
            else        mem_q[g] <= mem_d[g];
        end
    end

    assign rdata_o     = mem_q[raddr_i];
    assign pdata_o     = mem_q[paddr_i];
    assign cfg_lsb_o   = mem_q[0][CFG_LSB_BIT];
    assign cfg_bidir_o = mem_q[0][CFG_BIDIR_BIT];

endmodule

// File: rtl/serreg_ctrl.sv
module serreg_ctrl
    import serreg_pkg::*;
#(
    parameter  int AW = ADDR_W,
    parameter  int DW = DATA_W,
    localparam int CW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_i,
    input  logic          fall_i,
    input  logic          done_i,
    input  logic [DW-1:0] byte_i,
    input  logic [CW-1:0] bitcnt_i,
    input  logic          lsb_i,
    output logic [AW-1:0] raddr_o,
    input  logic [DW-1:0] rdata_i,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic [DW-1:0] wdata_o,
    output logic          rd_phase_o,
    output logic          out_o
);

    typedef struct packed {
        phase_e           phase;
        logic [AW-1:0]    addr;
        logic [CNT_W-1:0] cnt;
        logic [DW-1:0]    tx;
        logic             out;
    } ctl_st_t;

    ctl_st_t       st_d, st_q;
    logic          lsb_eff;
    logic [AW-1:0] addr_step;

    // Step direction honours a configuration byte completing in this cycle.
    always_comb begin
        lsb_eff = lsb_i;
        if (st_q.phase == PH_WR && st_q.addr == '0) lsb_eff = byte_i[CFG_LSB_BIT];
        addr_step = lsb_eff ? st_q.addr + AW'(1) : st_q.addr - AW'(1);
        raddr_o   = (st_q.phase == PH_INSTR) ? byte_i[AW-1:0] : addr_step;
    end

    always_comb begin
        st_d    = st_q;
        we_o    = 1'b0;
        waddr_o = st_q.addr;
        wdata_o = byte_i;
        if (!cs_i) begin
            st_d.phase = PH_INSTR;
            st_d.cnt   = '0;
        end else begin
            if (done_i) begin
                st_d.tx = rdata_i;
                unique case (st_q.phase)
                    PH_INSTR: begin
                        st_d.addr  = byte_i[AW-1:0];
                        st_d.cnt   = byte_i[DW-2 -: CNT_W];
                        st_d.phase = byte_i[DW-1] ? PH_RD : PH_WR;
                    end
                    PH_WR, PH_RD: begin
                        we_o      = (st_q.phase == PH_WR);
                        st_d.addr = addr_step;
                        if (st_q.cnt == '0) st_d.phase = PH_DONE;
                        else                st_d.cnt   = st_q.cnt - CNT_W'(1);
                    end
                    default: ;
                endcase
            end
            if (fall_i && st_q.phase == PH_RD)
                st_d.out = st_q.tx[lsb_i ? bitcnt_i : (CW'(DW - 1) - bitcnt_i)];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_INSTR;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_phase_o = (st_q.phase == PH_RD);
    assign out_o      = st_q.out;

endmodule

// File: rtl/serreg_slave.sv
module serreg_slave
    import serreg_pkg::*;
#(
    parameter int HOLD_IDX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_csn,
    input  logic              spi_sclk,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic              sdo_o,
    output logic              sdo_oe,
    input  logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_data
);

    localparam int CW = $clog2(DATA_W);

    logic              cs_act, sck_rise, sck_fall;
    logic              byte_done, cfg_lsb_w, cfg_bidir_w;
    logic [DATA_W-1:0] byte_val, rdata_w, wdata_w;
    logic [CW-1:0]     bitcnt_w;
    logic [ADDR_W-1:0] raddr_w, waddr_w;
    logic              we_w, rd_phase_w, out_w, rd_active;

    assign cs_act = ~spi_csn;

    serreg_edge u_sck (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (spi_sclk),
        .rise_o (sck_rise),
        .fall_o (sck_fall)
    );

    serreg_shifter #(.W(DATA_W)) u_shf (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (spi_csn),
        .take_i      (sck_rise & cs_act),
        .bit_i       (sdio_i),
        .lsb_first_i (cfg_lsb_w),
        .done_o      (byte_done),
        .byte_o      (byte_val),
        .count_o     (bitcnt_w)
    );

    serreg_ctrl #(.AW(ADDR_W), .DW(DATA_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_i       (cs_act),
        .fall_i     (sck_fall),
        .done_i     (byte_done),
        .byte_i     (byte_val),
        .bitcnt_i   (bitcnt_w),
        .lsb_i      (cfg_lsb_w),
        .raddr_o    (raddr_w),
        .rdata_i    (rdata_w),
        .we_o       (we_w),
        .waddr_o    (waddr_w),
        .wdata_o    (wdata_w),
        .rd_phase_o (rd_phase_w),
        .out_o      (out_w)
    );

    serreg_regfile #(.AW(ADDR_W), .DW(DATA_W), .HOLD_IDX(HOLD_IDX)) u_rf (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (we_w),
        .waddr_i     (waddr_w),
        .wdata_i     (wdata_w),
        .raddr_i     (raddr_w),
        .rdata_o     (rdata_w),
        .paddr_i     (rf_addr),
        .pdata_o     (rf_data),
        .cfg_lsb_o   (cfg_lsb_w),
        .cfg_bidir_o (cfg_bidir_w)
    );

    assign rd_active = cs_act & rd_phase_w;
    assign sdio_oe   = rd_active & cfg_bidir_w;
    assign sdo_oe    = rd_active & ~cfg_bidir_w;
    assign sdio_o    = out_w;
    assign sdo_o     = out_w;

endmodule

// File: rtl/serreg_checker.sv
module serreg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_csn,
    input logic       spi_sclk,
    input logic       sdio_oe,
    input logic       sdo_oe,
    input logic       sdo_o,
    input logic       cfg_bidir,
    input logic [4:0] rf_addr,
    input logic [7:0] rf_data
);

    p_oe_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_csn |-> (!sdio_oe && !sdo_oe));

    p_oe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sdio_oe, sdo_oe}));

    p_sdio_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> cfg_bidir);

    p_sdo_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> !cfg_bidir);

    p_out_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_o) |-> ($past(spi_sclk, 2) && !$past(spi_sclk)));

    p_srst_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_addr == 5'd0) |-> !rf_data[5]);

endmodule

bind serreg_slave serreg_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_csn   (spi_csn),
    .spi_sclk  (spi_sclk),
    .sdio_oe   (sdio_oe),
    .sdo_oe    (sdo_oe),
    .sdo_o     (sdo_o),
    .cfg_bidir (cfg_bidir_w),
    .rf_addr   (rf_addr),
    .rf_data   (rf_data)
);

// File: tb/sim_serreg_slave.sv
module sim_serreg_slave;

    logic       clk = 1'b0, rst_n = 1'b0, csn = 1'b1, sclk = 1'b0, din = 1'b0;
    logic       sdio_o, sdio_oe, sdo_o, sdo_oe;
    logic [4:0] rf_addr = 5'd0;
    logic [7:0] rf_data;
    logic [7:0] mref [32];
    int         n_chk = 0, n_fail = 0;
    bit         mon_on = 1'b0, finished = 1'b0;

    always #2.5ns clk = ~clk;   // 200 MHz

    serreg_slave u0 (
        .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sclk(sclk), .sdio_i(din),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
        .rf_addr(rf_addr), .rf_data(rf_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dflt(input int a);
        return (a == 0) ? 8'h00 : {3'b101, 5'(a)};
    endfunction

    // Model of the bank: effect of one completed write byte (R8 soft reset included).
    task automatic apply_write(input logic [4:0] a, input logic [7:0] v);
        if (a == 5'd0 && v[5]) begin
            for (int i = 1; i < 32; i++) if (i != 4) mref[i] = dflt(i);
            mref[0] = v & 8'hDF;
        end else begin
            mref[a] = v;
        end
    endtask

    // R9: parallel port against the model on every clock.
    always @(posedge clk) rf_addr <= rf_addr + 5'd1;
    always @(negedge clk) if (mon_on) check("R9 parallel port vs model", rf_data, mref[rf_addr]);

    task automatic bit_hi(input logic b, output logic rb, output logic [1:0] oe);
        @(negedge clk);
        din = b;
        repeat (2) @(negedge clk);
        rb   = mref[0][7] ? sdio_o : sdo_o;
        oe   = {sdio_oe, sdo_oe};
        sclk = 1'b1;
        @(posedge clk);
        #1ns;
    endtask

    task automatic bit_lo();
        repeat (3) @(negedge clk);
        sclk = 1'b0;
    endtask

    // Leaves SCLK high just after the edge that takes the last bit.
    task automatic xfer_byte(input logic [7:0] v, input logic rd, output logic [7:0] got);
        logic       lsb;
        logic [1:0] oe_exp;
        bit         oe_bad;
        lsb    = mref[0][6];
        oe_exp = rd ? (mref[0][7] ? 2'b10 : 2'b01) : 2'b00;
        oe_bad = 1'b0;
        got    = 8'h00;
        for (int i = 0; i < 8; i++) begin
            int         k;
            logic       rb;
            logic [1:0] oe;
            k = lsb ? i : 7 - i;
            bit_hi(v[k], rb, oe);
            got[k] = rb;
            if (oe !== oe_exp) oe_bad = 1'b1;
            if (i < 7) bit_lo();
        end
        check("R6 output enable pattern", 32'(oe_bad), 32'd0);
    endtask

    task automatic finish_txn();
        @(negedge clk) csn = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 enables low while deselected", {sdio_oe, sdo_oe}, 2'b00);
    endtask

    task automatic spi_write(input logic [4:0] a0, input int n, input logic [31:0] dat, input int extra);
        logic [7:0] g;
        logic [4:0] a;
        a = a0;
        @(negedge clk) csn = 1'b0;
        xfer_byte({1'b0, 2'(n - 1), a0}, 1'b0, g);
        bit_lo();
        for (int k = 0; k < n; k++) begin
            xfer_byte(dat[8*k +: 8], 1'b0, g);
            apply_write(a, dat[8*k +: 8]);
            a = mref[0][6] ? a + 5'd1 : a - 5'd1;
            bit_lo();
        end
        for (int k = 0; k < extra; k++) begin
            xfer_byte(8'h00, 1'b0, g);
            bit_lo();
        end
        finish_txn();
    endtask

    task automatic spi_read(input logic [4:0] a0, input int n, input string tag);
        logic [7:0] g, e;
        logic [4:0] a;
        a = a0;
        @(negedge clk) csn = 1'b0;
        xfer_byte({1'b1, 2'(n - 1), a0}, 1'b0, g);
        bit_lo();
        for (int k = 0; k < n; k++) begin
            e = mref[a];
            xfer_byte(8'h00, 1'b1, g);
            check(tag, g, e);
            a = mref[0][6] ? a + 5'd1 : a - 5'd1;
            bit_lo();
        end
        finish_txn();
    endtask

    task automatic partial(input int nb, input logic v);
        logic       rb;
        logic [1:0] oe;
        @(negedge clk) csn = 1'b0;
        for (int i = 0; i < nb; i++) begin
            bit_hi(v, rb, oe);
            bit_lo();
        end
        finish_txn();
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mref[i] = dflt(i);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        check("R9 default after reset", rf_data, dflt(rf_addr));
        check("R1 enables low after reset", {sdio_oe, sdo_oe}, 2'b00);

        // R2 R3: single byte, MSB first, 4-wire read on the separate pin
        spi_write(5'd5, 1, 32'h0000_003C, 0);
        spi_read(5'd5, 1, "R2 R5 single read");
        // R4: four bytes stepping down from 10
        spi_write(5'd10, 4, 32'hD4C3_B2A1, 0);
        spi_read(5'd10, 4, "R4 R5 descending read");
        // R4: wrap below zero
        spi_read(5'd0, 2, "R4 wrap below zero");
        // R4: byte past the count writes nothing
        spi_write(5'd20, 1, 32'h0000_0099, 1);
        spi_read(5'd19, 2, "R4 bytes past count ignored");
        // R3: LSB-first order, ascending with wrap above 31
        spi_write(5'd0, 1, 32'h0000_0040, 0);
        spi_write(5'd29, 3, 32'h0066_5544, 0);
        spi_read(5'd30, 3, "R3 R4 ascending wrap read");
        // R6: 3-wire mode, data on the shared pin
        spi_write(5'd0, 1, 32'h0000_00C0, 0);
        spi_read(5'd7, 2, "R6 shared pin read");
        // R7: configuration rewritten mid-transfer
        spi_write(5'd0, 2, 32'h0000_5A00, 0);
        spi_read(5'd31, 2, "R7 new order and step after config byte");
        // R8: soft reset keeps registers 0 and 4
        spi_write(5'd4, 1, 32'h0000_0077, 0);
        spi_write(5'd12, 1, 32'h0000_0033, 0);
        spi_write(5'd0, 1, 32'h0000_0020, 0);
        spi_read(5'd12, 1, "R8 restored register");
        spi_read(5'd4, 1, "R8 held register");
        spi_read(5'd0, 1, "R8 reset bit clears");
        // R1: partial byte discarded
        partial(5, 1'b1);
        spi_write(5'd3, 1, 32'h0000_0066, 0);
        spi_read(5'd3, 1, "R1 transfer after aborted byte");
        // R10: recovery from LSB-first with the long-instruction flag set
        spi_write(5'd0, 1, 32'h0000_0050, 0);
        partial(3, 1'b0);
        spi_write(5'd0, 1, 32'h0000_0000, 1);
        check("R10 configuration back to zero", mref[0], 8'h00);
        spi_read(5'd0, 1, "R10 recovered read");

        repeat (10) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule